// File: doc/BRIEF.md
# DDC EDID Block Reader

This block fetches one 128-byte EDID block from an attached display over the two-wire DDC bus. Software first sets up the transfer on its inputs: the display's EDID bus address, the byte offset to start at, the address of the segment-pointer register and the segment number. It then strobes start. The block drives the entire exchange by itself. It opens with a segment-pointer write and follows with a write of the byte offset. A repeated START then begins the read phase, which takes in 128 bytes.

Each received byte goes into a local buffer that the host reads through a combinational read port. A sticky completion flag reports a successful fetch. If the display fails to acknowledge any byte the block writes, the block sets an error flag instead. The bit engine that generates the bus timing is part of the block. The SCL rate comes from a quarter-period divider input; a typical setting is 39. Successive blocks are fetched by repeating the operation with offsets 0, 128 and so on, and with the segment number raised every two blocks.

Top module: `edid_fetch`

## Requirements
- R1: After reset the block is idle: busy_o, done_o and err_o are 0, scl_o is 1 and sda_oe_o is 0.
- R2: A start_i strobe while idle produces, in this order: START; seg_addr_i; seg_num_i; repeated START; dev_addr_i with bit 0 forced to 0; word_offs_i; repeated START; dev_addr_i with bit 0 forced to 1; 128 read bytes; STOP. Bytes are sent MSB first.
- R3: The n-th byte read (n = 0..127) is stored in buffer entry n. rd_data_o shows the entry selected by rd_addr_i in the same cycle.
- R4: The block acknowledges each of the first 127 read bytes by pulling SDA low in the ninth clock. It leaves the 128th byte unacknowledged and then issues STOP.
- R5: done_o rises when the STOP of a successful fetch completes. It stays at 1 until done_clr_i is strobed or a new fetch is accepted.
- R6: If any of the five written bytes is not acknowledged (SDA high in its ninth clock), the block issues STOP and sends no further bytes. It then leaves err_o at 1 and done_o at 0.
- R7: A start_i strobe while busy_o is 1 has no effect on the transfer in progress.
- R8: Every SCL phase lasts scl_div_i+1 clock cycles. During a byte, SCL is high for 2*(scl_div_i+1) cycles per bit.
- R9: done_o and err_o are never 1 together. Whenever busy_o is 0, the bus is released (scl_o 1, sda_oe_o 0).
- R10: During byte transfers, sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that begins a fetch |
| done_clr_i | input | 1 | One-cycle strobe that clears done_o |
| dev_addr_i | input | 8 | EDID bus address byte (0xA0 typical); bit 0 is replaced by the block |
| word_offs_i | input | 8 | Starting byte offset inside the segment |
| seg_addr_i | input | 8 | Segment-pointer address byte (0x60 typical) |
| seg_num_i | input | 8 | Segment number |
| scl_div_i | input | DIV_W | Quarter-period divider, held stable during a fetch |
| rd_addr_i | input | IDX_W | Buffer read index |
| rd_data_o | output | 8 | Buffer entry at rd_addr_i |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | Sticky completion flag |
| err_o | output | 1 | Missing acknowledge on a written byte |
| scl_o | output | 1 | SCL level (1 = released) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The hardest case to reach is a missing acknowledge on one particular written byte. For example, the display may accept the segment pointer and then reject the offset. In that case the block must stop mid-sequence without touching the buffer or the completion flag. The bench drives the bus with a behavioural display model whose NACK position is a variable. Random and directed runs cover each of the five written byte positions, plus rejected segment and EDID addresses. The model also checks the SCL high time of every read bit, and a second start strobe is fired in the middle of a fetch.

// File: rtl/edid_fetch_pkg.sv
package edid_fetch_pkg;

  typedef enum logic [1:0] {
    BC_START = 2'd0,
    BC_STOP  = 2'd1,
    BC_WRITE = 2'd2,
    BC_READ  = 2'd3
  } bit_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_START    = 4'd1,
    ST_SEG_ADDR = 4'd2,
    ST_SEG_NUM  = 4'd3,
    ST_RSTART1  = 4'd4,
    ST_DEV_WR   = 4'd5,
    ST_OFFSET   = 4'd6,
    ST_RSTART2  = 4'd7,
    ST_DEV_RD   = 4'd8,
    ST_READ     = 4'd9,
    ST_STOP     = 4'd10
  } step_e;

endpackage

// File: rtl/edid_bit_eng.sv
module edid_bit_eng
  import edid_fetch_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cmd_vld_i,
  input  bit_cmd_e         cmd_i,
  input  logic [7:0]       wdata_i,
  input  logic             ack_i,
  input  logic             sda_i,
  output logic             done_o,
  output logic [7:0]       rdata_o,
  output logic             nack_o,
  output logic             active_o,
  output logic             scl_o,
  output logic             sda_oe_o
);

  localparam logic [3:0] ACK_BIT = 4'd8;

  logic             active_q;
  bit_cmd_e         cmd_q;
  logic [1:0]       qtr_q;
  logic [3:0]       bit_q;
  logic [7:0]       sh_q;
  logic             ack_q;
  logic [DIV_W-1:0] cnt_q;
  logic             scl_q, sda_oe_q, nack_q, done_q;
  logic             tick, is_byte, last_qtr, drive_bit;

  assign tick     = active_q && (cnt_q == div_i);
  assign is_byte  = (cmd_q == BC_WRITE) || (cmd_q == BC_READ);
  assign last_qtr = (qtr_q == 2'd3) && (!is_byte || bit_q == ACK_BIT);

  // 1 = pull SDA low for the current bit
  always_comb begin
    if (cmd_q == BC_WRITE) drive_bit = (bit_q == ACK_BIT) ? 1'b0 : ~sh_q[7];
    else                   drive_bit = (bit_q == ACK_BIT) ? ack_q : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cmd_q    <= BC_STOP;
      qtr_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      ack_q    <= 1'b0;
      cnt_q    <= '0;
      scl_q    <= 1'b1;
      sda_oe_q <= 1'b0;
      nack_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (cmd_vld_i) begin
          active_q <= 1'b1;
          cmd_q    <= cmd_i;
          qtr_q    <= '0;
          bit_q    <= '0;
          sh_q     <= wdata_i;
          ack_q    <= ack_i;
          cnt_q    <= '0;
          nack_q   <= 1'b0;
        end
      end else if (!tick) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        qtr_q <= qtr_q + 2'd1;
        unique case (cmd_q)
          BC_START: begin
            case (qtr_q)
              2'd0:    begin scl_q <= 1'b0; sda_oe_q <= 1'b0; end
              2'd1:    scl_q <= 1'b1;
              2'd2:    sda_oe_q <= 1'b1;
              default: scl_q <= 1'b0;
            endcase
          end
          BC_STOP: begin
            case (qtr_q)
              2'd0:    begin scl_q <= 1'b0; sda_oe_q <= 1'b1; end
              2'd1:    scl_q <= 1'b1;
              2'd2:    sda_oe_q <= 1'b0;
              default: ;
            endcase
          end
          default: begin
            case (qtr_q)
              2'd0: begin scl_q <= 1'b0; sda_oe_q <= drive_bit; end
              2'd1: scl_q <= 1'b1;
              2'd2: begin
                if (bit_q != ACK_BIT)        sh_q   <= {sh_q[6:0], sda_i};
                else if (cmd_q == BC_WRITE)  nack_q <= sda_i;
              end
              default: begin
                scl_q <= 1'b0;
                bit_q <= bit_q + 4'd1;
              end
            endcase
          end
        endcase
        if (last_qtr) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign done_o   = done_q;
  assign rdata_o  = sh_q;
  assign nack_o   = nack_q;
  assign active_o = active_q;
  assign scl_o    = scl_q;
  assign sda_oe_o = sda_oe_q;

  AST_SDA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && is_byte && scl_q && $past(scl_q) && $past(active_q)) |-> $stable(sda_oe_q)); // R10

  AST_CMD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_i |-> !active_q); // R2

endmodule

// File: rtl/edid_seq.sv
module edid_seq
  import edid_fetch_pkg::*;
#(
  parameter int unsigned BLK_BYTES = 128,
  parameter int unsigned IDX_W     = $clog2(BLK_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             done_clr_i,
  input  logic [7:0]       dev_addr_i,
  input  logic [7:0]       word_offs_i,
  input  logic [7:0]       seg_addr_i,
  input  logic [7:0]       seg_num_i,
  input  logic             eng_done_i,
  input  logic             eng_nack_i,
  input  logic [7:0]       eng_rdata_i,
  output logic             cmd_vld_o,
  output bit_cmd_e         cmd_o,
  output logic [7:0]       wdata_o,
  output logic             ack_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_BYTES - 1);

  step_e            step_q;
  logic             issued_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q, err_q;
  logic             is_wr_step;

  function automatic step_e next_step(step_e s);
    case (s)
      ST_START:    return ST_SEG_ADDR;
      ST_SEG_ADDR: return ST_SEG_NUM;
      ST_SEG_NUM:  return ST_RSTART1;
      ST_RSTART1:  return ST_DEV_WR;
      ST_DEV_WR:   return ST_OFFSET;
      ST_OFFSET:   return ST_RSTART2;
      ST_RSTART2:  return ST_DEV_RD;
      ST_DEV_RD:   return ST_READ;
      default:     return ST_IDLE;
    endcase
  endfunction

  assign busy_o    = (step_q != ST_IDLE);
  assign cmd_vld_o = busy_o && !issued_q;

  always_comb begin
    cmd_o      = BC_WRITE;
    wdata_o    = 8'h00;
    ack_o      = 1'b0;
    is_wr_step = 1'b0;
    case (step_q)
      ST_START, ST_RSTART1, ST_RSTART2: cmd_o = BC_START;
      ST_SEG_ADDR: begin wdata_o = seg_addr_i;               is_wr_step = 1'b1; end
      ST_SEG_NUM:  begin wdata_o = seg_num_i;                is_wr_step = 1'b1; end
      ST_DEV_WR:   begin wdata_o = {dev_addr_i[7:1], 1'b0};  is_wr_step = 1'b1; end
      ST_OFFSET:   begin wdata_o = word_offs_i;              is_wr_step = 1'b1; end
      ST_DEV_RD:   begin wdata_o = {dev_addr_i[7:1], 1'b1};  is_wr_step = 1'b1; end
      ST_READ:     begin cmd_o = BC_READ; ack_o = (idx_q != LAST_IDX); end
      ST_STOP:     cmd_o = BC_STOP;
      default:     ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= ST_IDLE;
      issued_q <= 1'b0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else if (start_i && !busy_o) begin
      step_q   <= ST_START;
      issued_q <= 1'b0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (done_clr_i) done_q <= 1'b0;
      if (cmd_vld_o) issued_q <= 1'b1;
      if (eng_done_i) begin
        issued_q <= 1'b0;
        if (is_wr_step) begin
          if (eng_nack_i) begin
            step_q <= ST_STOP;
            err_q  <= 1'b1;
          end else begin
            step_q <= next_step(step_q);
          end
        end else if (step_q == ST_READ) begin
          if (idx_q == LAST_IDX) step_q <= ST_STOP;
          else                   idx_q  <= idx_q + 1'b1;
        end else if (step_q == ST_STOP) begin
          step_q <= ST_IDLE;
          if (!err_q) done_q <= 1'b1;
        end else begin
          step_q <= next_step(step_q);
        end
      end
    end
  end

  assign wr_en_o   = eng_done_i && (step_q == ST_READ);
  assign wr_idx_o  = idx_q;
  assign wr_data_o = eng_rdata_i;
  assign done_o    = done_q;
  assign err_o     = err_q;

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && err_q)); // R9

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !done_clr_i && !start_i) |=> done_q); // R5

  AST_NACK_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && eng_nack_i && is_wr_step) |=> (step_q == ST_STOP && err_q)); // R6

endmodule

// File: rtl/edid_buf.sv
module edid_buf #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];

endmodule

// File: rtl/edid_fetch.sv
module edid_fetch
  import edid_fetch_pkg::*;
#(
  parameter  int unsigned BLK_BYTES = 128,
  parameter  int unsigned DIV_W     = 8,
  localparam int unsigned IDX_W     = $clog2(BLK_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             done_clr_i,
  input  logic [7:0]       dev_addr_i,
  input  logic [7:0]       word_offs_i,
  input  logic [7:0]       seg_addr_i,
  input  logic [7:0]       seg_num_i,
  input  logic [DIV_W-1:0] scl_div_i,
  input  logic [IDX_W-1:0] rd_addr_i,
  output logic [7:0]       rd_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             scl_o,
  output logic             sda_oe_o,
  input  logic             sda_i
);

  logic             cmd_vld, ack, eng_done, eng_nack, eng_active;
  bit_cmd_e         cmd;
  logic [7:0]       wdata, eng_rdata, wr_data;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             unused_eng_active;

  assign unused_eng_active = eng_active;

  edid_seq #(.BLK_BYTES(BLK_BYTES), .IDX_W(IDX_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .done_clr_i  (done_clr_i),
    .dev_addr_i  (dev_addr_i),
    .word_offs_i (word_offs_i),
    .seg_addr_i  (seg_addr_i),
    .seg_num_i   (seg_num_i),
    .eng_done_i  (eng_done),
    .eng_nack_i  (eng_nack),
    .eng_rdata_i (eng_rdata),
    .cmd_vld_o   (cmd_vld),
    .cmd_o       (cmd),
    .wdata_o     (wdata),
    .ack_o       (ack),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .wr_data_o   (wr_data),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  edid_bit_eng #(.DIV_W(DIV_W)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (scl_div_i),
    .cmd_vld_i (cmd_vld),
    .cmd_i     (cmd),
    .wdata_i   (wdata),
    .ack_i     (ack),
    .sda_i     (sda_i),
    .done_o    (eng_done),
    .rdata_o   (eng_rdata),
    .nack_o    (eng_nack),
    .active_o  (eng_active),
    .scl_o     (scl_o),
    .sda_oe_o  (sda_oe_o)
  );

  edid_buf #(.DEPTH(BLK_BYTES), .IDX_W(IDX_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  AST_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (scl_o && !sda_oe_o)); // R9

endmodule

// File: tb/edid_fetch_test.sv
`timescale 1ns/1ps
module edid_fetch_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, done_clr = 1'b0;
  logic [7:0] dev_addr = 8'hA0, word_offs = 8'h00, seg_addr = 8'h60, seg_num = 8'h00;
  logic [7:0] scl_div = 8'd1;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy, done, err, scl, sda_oe;
  logic       sl_drv = 1'b0;
  wire        sda_line = ~(sda_oe | sl_drv);

  always #2 clk = ~clk;

  edid_fetch uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_clr_i(done_clr),
    .dev_addr_i(dev_addr), .word_offs_i(word_offs), .seg_addr_i(seg_addr),
    .seg_num_i(seg_num), .scl_div_i(scl_div), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_o(busy), .done_o(done), .err_o(err),
    .scl_o(scl), .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  int n_chk = 0, n_fail = 0;
  bit wd_hit = 1'b0;

  function automatic logic [7:0] rom_byte(int a);
    return 8'((a * 37 + 11) ^ (a >> 8));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // display model
  localparam int SL_IDLE = 0, SL_ADDR = 1, SL_WDATA = 2, SL_RDATA = 3, SL_IGN = 4;
  int sl_state = SL_IDLE, bitc = 0, nack_idx = -1, exp_hi = 4;
  int wcnt = 0, rcnt = 0, macks = 0, nack_pos = -1, starts = 0, stops = 0;
  int bad_w = 0, meas_w = 0, ptr = 0, seg = 0;
  logic [7:0] wlog [16];
  logic [7:0] sh = '0, tx = '0, cur_byte = '0;
  bit cur_ok = 1'b0, last_mack = 1'b0, tgt_seg = 1'b0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  int hi_cnt = 0;

  always @(negedge clk) hi_cnt <= scl ? hi_cnt + 1 : 0;

  always @(scl or sda_line) begin
    if (scl && prev_scl && prev_sda && !sda_line) begin
      if (sl_state == SL_IDLE) begin
        wcnt = 0; rcnt = 0; macks = 0; nack_pos = -1; starts = 0; stops = 0;
        bad_w = 0; meas_w = 0; seg = 0;
      end
      starts++; sl_state = SL_ADDR; bitc = 0; sl_drv = 1'b0;
    end else if (scl && prev_scl && !prev_sda && sda_line) begin
      stops++; sl_state = SL_IDLE; sl_drv = 1'b0;
    end else if (scl && !prev_scl) begin
      if (sl_state != SL_IDLE && sl_state != SL_IGN) begin
        if (bitc < 8 && sl_state != SL_RDATA) sh = {sh[6:0], sda_line};
        if (bitc == 8 && sl_state == SL_RDATA) begin
          rcnt++; last_mack = !sda_line;
          if (!sda_line) macks++; else nack_pos = rcnt;
        end
        bitc++;
      end
    end else if (!scl && prev_scl) begin
      if (sl_state == SL_RDATA) begin
        meas_w++;
        if (hi_cnt != exp_hi) bad_w++;
      end
      if (bitc == 8 && (sl_state == SL_ADDR || sl_state == SL_WDATA)) begin
        cur_byte = sh;
        cur_ok = (wcnt != nack_idx) &&
                 (sl_state != SL_ADDR || sh[7:1] == 7'h50 || sh[7:1] == 7'h30);
        if (wcnt < 16) wlog[wcnt] = sh;
        wcnt++;
        sl_drv = cur_ok;
      end else if (bitc == 8 && sl_state == SL_RDATA) begin
        sl_drv = 1'b0;
      end else if (bitc == 9) begin
        bitc = 0; sl_drv = 1'b0;
        case (sl_state)
          SL_ADDR: begin
            if (!cur_ok) sl_state = SL_IGN;
            else if (cur_byte[0]) begin
              sl_state = SL_RDATA; tx = rom_byte(ptr); ptr++; sl_drv = ~tx[7];
            end else begin
              sl_state = SL_WDATA; tgt_seg = (cur_byte[7:1] == 7'h30);
            end
          end
          SL_WDATA: begin
            if (!cur_ok) sl_state = SL_IGN;
            else if (tgt_seg) seg = int'(cur_byte);
            else ptr = seg * 256 + int'(cur_byte);
          end
          SL_RDATA: begin
            if (last_mack) begin tx = rom_byte(ptr); ptr++; sl_drv = ~tx[7]; end
            else sl_state = SL_IGN;
          end
          default: ;
        endcase
      end else if (sl_state == SL_RDATA && bitc >= 1 && bitc <= 7) begin
        sl_drv = ~tx[7 - bitc];
      end
    end
    prev_scl = scl; prev_sda = sda_line;
  end

  task automatic run(input logic [7:0] dv, input logic [7:0] of, input logic [7:0] sa,
                     input logic [7:0] sg, input int dvd, input int nk, input int fi,
                     input bit poke);
    @(negedge clk);
    dev_addr = dv; word_offs = of; seg_addr = sa; seg_num = sg;
    scl_div = 8'(dvd); nack_idx = nk; exp_hi = 2 * (dvd + 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    if (poke) begin
      repeat (3000) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (busy && !wd_hit) @(negedge clk);
    chk(scl && !sda_oe, "R9 bus released", {scl, sda_oe}, 2);
    chk(!(done && err), "R9 flags exclusive", {done, err}, 0);
    if (fi < 0) begin
      bit ok;
      int bad;
      ok = (wcnt == 5) && (wlog[0] == sa) && (wlog[1] == sg) &&
           (wlog[2] == {dv[7:1], 1'b0}) && (wlog[3] == of) && (wlog[4] == {dv[7:1], 1'b1});
      chk(ok, "R2 written byte order", wcnt, 5);
      chk(starts == 3 && stops == 1, "R2 start/stop count", starts * 16 + stops, 3 * 16 + 1);
      chk(rcnt == 128 && macks == 127 && nack_pos == 128, "R4 ack pattern",
          macks, 127);
      chk(done == 1'b1 && err == 1'b0, "R5 done set", {done, err}, 2);
      chk(meas_w > 0 && bad_w == 0, "R8 SCL high time", bad_w, 0);
      bad = 0;
      for (int i = 0; i < 128; i++) begin
        rd_addr = 7'(i); #1;
        if (rd_data !== rom_byte(int'(sg) * 256 + int'(of) + i)) begin
          if (bad == 0)
            $display("FAIL R3: entry %0d actual 0x%0h expected 0x%0h", i, rd_data,
                     rom_byte(int'(sg) * 256 + int'(of) + i));
          bad++;
        end
      end
      n_chk++; if (bad != 0) n_fail++;
      repeat (40) @(negedge clk);
      chk(done == 1'b1, "R5 done sticky", done, 1);
      if (poke) chk(busy == 1'b0 && starts == 3, "R7 no restart", starts, 3);
      done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
      chk(done == 1'b0, "R5 done cleared", done, 0);
    end else begin
      chk(err == 1'b1 && done == 1'b0, "R6 error flag", {done, err}, 1);
      chk(wcnt == fi + 1 && rcnt == 0, "R6 no further bytes", wcnt, fi + 1);
      chk(stops == 1, "R6 stop issued", stops, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    wd_hit = 1'b1;
    n_chk++; n_fail++;
    $display("FAIL R2: watchdog expired, actual busy=%0d expected 0", busy);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && scl && !sda_oe, "R1 reset state",
        {busy, done, err, scl, sda_oe}, 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !err && scl && !sda_oe, "R1 idle after reset",
        {busy, done, err, scl, sda_oe}, 2);

    run(8'hA0, 8'h00, 8'h60, 8'h00, 1, -1, -1, 1'b0);
    run(8'hA1, 8'h80, 8'h60, 8'h00, 3, -1, -1, 1'b0);
    run(8'hA0, 8'h00, 8'h60, 8'h01, 1, -1, -1, 1'b1); // R7 start while busy
    for (int k = 0; k < 3; k++) begin
      logic [7:0] of, sg;
      int dvd;
      of  = 8'($urandom_range(0, 255));
      sg  = 8'($urandom_range(0, 3));
      dvd = $urandom_range(1, 2);
      run(8'hA0, of, 8'h60, sg, dvd, -1, -1, 1'b0);
    end
    for (int k = 0; k < 5; k++) run(8'hA0, 8'h80, 8'h60, 8'h00, 1, k, k, 1'b0); // R6
    run(8'hA4, 8'h00, 8'h60, 8'h00, 1, -1, 2, 1'b0); // R6 rejected EDID address
    run(8'hA0, 8'h00, 8'h62, 8'h00, 1, -1, 0, 1'b0); // R6 rejected segment address
    run(8'hA0, 8'h00, 8'h60, 8'h00, 1, -1, -1, 1'b0); // recovery after error

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule